// File: doc/BRIEF.md
# Flash factory-program sequencer

This block is the device-side controller for a bulk programming mode of a NOR-style flash. The mode is meant for the production line. After a two-word entry command, the host streams data words into one block. The block keeps a fixed block base and moves a word pointer forward on its own after each word. Each word gets a single program pulse.

A data-all-ones write to an address in another block closes the stream and opens a verify pass. In that pass the host replays the same words in the same order. The controller compares each one against the array and applies bounded retry pulses to bits that did not take. A second out-of-block all-ones write leaves the mode.

The host polls an 8-bit status word throughout. Errors stay latched until a clear command. A behavioural word array with a configurable pulse latency models the cells. Its weak words take a second pulse to clear their upper byte, and its stuck words never change.

Top module: `fpseq_top`

## Requirements
- R1: After reset the status word reads 80h: bit 7 (ready) is 1 and every other bit is 0.
- R2: A write of 0030h followed by a write of 00D0h to the same address starts setup. Bit 7 reads 0 for SETUP_CYC cycles after the confirm, then 1 with bit 0 at 0. A confirm with a different address or value returns to idle, and later stream writes there leave bit 0 at 0.
- R3: At confirm, a missing programming voltage sets bit 3 and a locked target block sets bit 1. Bit 7 stays 1 and the mode is not entered.
- R4: In the program phase, a write inside the block issues exactly one pulse. Bit 0 reads 1 from the write edge and returns to 0 PULSE_LAT cycles later.
- R5: The word pointer starts at the word offset of the entry address and steps by one after every program-phase or verify-phase word. The address bits of a stream write below the block field are ignored.
- R6: A write of FFFFh outside the current block ends the program phase and opens verify. FFFFh inside the block is ordinary data. An out-of-block write of any other value is ignored.
- R7: In verify, a matching word keeps bit 0 high for 1 cycle. A mismatching word gets up to MAX_RETRY retry pulses, each ANDing the replayed word into the cell, with a compare after each. A word that matches after one retry is busy for PULSE_LAT+2 cycles and leaves bit 4 at 0.
- R8: A word that still mismatches after MAX_RETRY retries sets bit 4 (busy for MAX_RETRY*(PULSE_LAT+1)+1 cycles). Bit 4 stays set after exit.
- R9: A write of FFFFh outside the block during verify starts exit. Bit 7 reads 0 for EXIT_CYC cycles and then returns to 1.
- R10: A write of 0050h in idle clears bits 4, 3 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | AW | Write address: block field above WORD_BITS word-offset bits |
| bus_wdata | input | DW | Write data or command code |
| hv_ok | input | 1 | Programming voltage present |
| blk_lock | input | NUM_BLOCKS | Per-block lock bits |
| status | output | 8 | Status word: 7 ready, 4 program fail, 3 voltage error, 1 lock error, 0 busy |

## Verification
Every result comes from registered state, so it is visible half a cycle after the write edge that causes it. Error flags and the start of setup or exit show at once. Setup and exit end SETUP_CYC and EXIT_CYC cycles later. A program word is busy for PULSE_LAT cycles. A verify word is busy for 1, PULSE_LAT+2 or MAX_RETRY*(PULSE_LAT+1)+1 cycles, depending on whether it matches at once, needs one retry or fails. The bench drives and samples on the falling edge. It counts falling edges from each write until the busy bit drops and compares that count with the figure above, so a late or early result is reported as well as a wrong one.

// File: rtl/fpseq_pkg.sv
package fpseq_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_ARM,
      S_SETUP,
      S_PROG,
      S_PPULSE,
      S_VERIFY,
      S_VCMP,
      S_VPULSE,
      S_EXIT
   } fp_state_e;

   localparam logic [15:0] CMD_ENTER   = 16'h0030;
   localparam logic [15:0] CMD_CONFIRM = 16'h00D0;
   localparam logic [15:0] CMD_CLEAR   = 16'h0050;

   localparam int ST_RDY  = 7;
   localparam int ST_FAIL = 4;
   localparam int ST_VPP  = 3;
   localparam int ST_LOCK = 1;
   localparam int ST_BUSY = 0;
endpackage

// File: rtl/fpseq_ptr.sv
module fpseq_ptr #(
   parameter int WB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [WB-1:0] load_val,
   input  logic          inc,
   output logic [WB-1:0] ptr
);
   initial assert (WB >= 1) else $error("fpseq_ptr: WB must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (inc)  ptr <= ptr + 1'b1;
   end

   // R5: the pointer moves by exactly one word per accepted word
   p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inc) && !$past(load)) |-> (ptr == WB'($past(ptr) + 1'b1)))
      else $error("p_ptr_step_r5");
endmodule

// File: rtl/fpseq_array.sv
module fpseq_array #(
   parameter int          AW        = 4,
   parameter int          DW        = 16,
   parameter int          PULSE_LAT = 2,
   parameter logic [63:0] WEAK_MAP  = 64'h0,
   parameter logic [63:0] STUCK_MAP = 64'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pgm_req,
   input  logic [AW-1:0] pgm_addr,
   input  logic [DW-1:0] pgm_data,
   output logic          pgm_done,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int          NW = 1 << AW;
   localparam int          CW = (PULSE_LAT > 1) ? $clog2(PULSE_LAT) : 1;
   localparam logic [DW-1:0] HI_KEEP = {{(DW/2){1'b1}}, {(DW-DW/2){1'b0}}};

   initial assert (NW <= 64)       else $error("fpseq_array: at most 64 words");
   initial assert (PULSE_LAT >= 1) else $error("fpseq_array: PULSE_LAT >= 1");

   logic          pend;
   logic [AW-1:0] a_q;
   logic [DW-1:0] d_q;
   logic [DW-1:0] mem [NW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         a_q  <= '0;
         d_q  <= '0;
      end else if (pgm_req) begin
         pend <= 1'b1;
         a_q  <= pgm_addr;
         d_q  <= pgm_data;
      end else if (pgm_done) begin
         pend <= 1'b0;
      end
   end

   generate
      if (PULSE_LAT == 1) begin : g_direct
         assign pgm_done = pend;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt <= '0;
            else if (pgm_req)           cnt <= CW'(PULSE_LAT - 1);
            else if (pend && cnt != '0) cnt <= cnt - 1'b1;
         end
         assign pgm_done = pend && (cnt == '0);
      end

      for (genvar w = 0; w < NW; w++) begin : g_word
         localparam bit IS_WEAK  = WEAK_MAP[w];
         localparam bit IS_STUCK = STUCK_MAP[w];
         logic [DW-1:0] word_q;
         logic          hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '1;
               hit_q  <= 1'b0;
            end else if (pgm_done && a_q == AW'(w)) begin
               hit_q <= 1'b1;
               if (!IS_STUCK) begin
                  if (IS_WEAK && !hit_q) word_q <= word_q & (d_q | HI_KEEP);
                  else                   word_q <= word_q & d_q;
               end
            end
         end
         assign mem[w] = word_q;
      end
   endgenerate

   assign rd_data = mem[rd_addr];

   // R4: a new pulse is never requested while one is still in flight
   p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_req |-> !pend)
      else $error("p_no_overlap_r4");
endmodule

// File: rtl/fpseq_status.sv
module fpseq_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_fail,
   input  logic       set_vpp,
   input  logic       set_lock,
   input  logic       clr,
   input  logic       rdy,
   input  logic       busy,
   output logic [7:0] status
);
   import fpseq_pkg::*;

   logic f_fail, f_vpp, f_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_fail <= 1'b0;
         f_vpp  <= 1'b0;
         f_lock <= 1'b0;
      end else if (clr) begin
         f_fail <= 1'b0;
         f_vpp  <= 1'b0;
         f_lock <= 1'b0;
      end else begin
         f_fail <= f_fail | set_fail;
         f_vpp  <= f_vpp  | set_vpp;
         f_lock <= f_lock | set_lock;
      end
   end

   always_comb begin
      status          = '0;
      status[ST_RDY]  = rdy;
      status[ST_FAIL] = f_fail;
      status[ST_VPP]  = f_vpp;
      status[ST_LOCK] = f_lock;
      status[ST_BUSY] = busy;
   end

   // R8: the program-fail flag only drops on a clear command
   p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(f_fail) && !$past(clr)) |-> f_fail)
      else $error("p_fail_sticky_r8");
endmodule

// File: rtl/fpseq_top.sv
module fpseq_top #(
   parameter int          WORD_BITS  = 3,
   parameter int          NUM_BLOCKS = 2,
   parameter int          DW         = 16,
   parameter int          PULSE_LAT  = 2,
   parameter int          MAX_RETRY  = 3,
   parameter int          SETUP_CYC  = 4,
   parameter int          EXIT_CYC   = 3,
   parameter logic [63:0] WEAK_MAP   = 64'h0000_0000_0000_0400,
   parameter logic [63:0] STUCK_MAP  = 64'h0000_0000_0000_0020,
   localparam int         BB         = $clog2(NUM_BLOCKS),
   localparam int         AW         = BB + WORD_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [AW-1:0]         bus_addr,
   input  logic [DW-1:0]         bus_wdata,
   input  logic                  hv_ok,
   input  logic [NUM_BLOCKS-1:0] blk_lock,
   output logic [7:0]            status
);
   import fpseq_pkg::*;

   localparam int MAXC = (SETUP_CYC > EXIT_CYC) ? SETUP_CYC : EXIT_CYC;
   localparam int TW   = $clog2(MAXC + 1);
   localparam int RW   = $clog2(MAX_RETRY + 1);

   initial assert (NUM_BLOCKS >= 2 && (1 << BB) == NUM_BLOCKS)
      else $error("fpseq_top: NUM_BLOCKS must be a power of two >= 2");
   initial assert (DW >= 16)                     else $error("fpseq_top: DW >= 16");
   initial assert (SETUP_CYC >= 1 && EXIT_CYC >= 1) else $error("fpseq_top: cycle counts >= 1");
   initial assert (MAX_RETRY >= 1)               else $error("fpseq_top: MAX_RETRY >= 1");

   fp_state_e        st;
   logic [BB-1:0]    base_blk;
   logic [WORD_BITS-1:0] start_ofs;
   logic [AW-1:0]    arm_addr;
   logic [TW-1:0]    tmr;
   logic [RW-1:0]    tries;
   logic [DW-1:0]    vdata;

   logic [WORD_BITS-1:0] ptr;
   logic             pgm_req, pgm_done;
   logic [DW-1:0]    pgm_data, rd_data;
   logic [AW-1:0]    word_addr;

   logic in_blk, is_ones, end_mark, stream_wr, confirm_ok, cmp_eq;
   logic err_vpp, err_lock;
   logic ptr_load, ptr_inc;
   logic [WORD_BITS-1:0] ptr_val;
   logic set_fail, set_vpp, set_lock, clr_st;

   assign in_blk     = (bus_addr[AW-1:WORD_BITS] == base_blk);
   assign is_ones    = &bus_wdata;
   assign end_mark   = bus_wr && is_ones && !in_blk;
   assign stream_wr  = bus_wr && in_blk;
   assign confirm_ok = bus_wr && (bus_wdata == DW'(CMD_CONFIRM)) && (bus_addr == arm_addr);
   assign err_vpp    = !hv_ok;
   assign err_lock   = blk_lock[arm_addr[AW-1:WORD_BITS]];
   assign word_addr  = {base_blk, ptr};
   assign cmp_eq     = (rd_data == vdata);

   // pulse requests, pointer moves and flag updates
   always_comb begin
      pgm_req  = 1'b0;
      pgm_data = vdata;
      ptr_load = 1'b0;
      ptr_val  = start_ofs;
      ptr_inc  = 1'b0;
      set_fail = 1'b0;
      set_vpp  = 1'b0;
      set_lock = 1'b0;
      clr_st   = 1'b0;
      unique case (st)
         S_IDLE:  clr_st = bus_wr && (bus_wdata == DW'(CMD_CLEAR));
         S_ARM: if (confirm_ok) begin
            set_vpp  = err_vpp;
            set_lock = err_lock;
            ptr_load = 1'b1;
            ptr_val  = arm_addr[WORD_BITS-1:0];
         end
         S_PROG: begin
            if (stream_wr) begin
               pgm_req  = 1'b1;
               pgm_data = bus_wdata;
            end else if (end_mark) begin
               ptr_load = 1'b1;
            end
         end
         S_PPULSE: ptr_inc = pgm_done;
         S_VCMP: begin
            if (cmp_eq) begin
               ptr_inc = 1'b1;
            end else if (tries == RW'(MAX_RETRY)) begin
               ptr_inc  = 1'b1;
               set_fail = 1'b1;
            end else begin
               pgm_req = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         base_blk  <= '0;
         start_ofs <= '0;
         arm_addr  <= '0;
         tmr       <= '0;
         tries     <= '0;
         vdata     <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (bus_wr && bus_wdata == DW'(CMD_ENTER)) begin
               arm_addr <= bus_addr;
               st       <= S_ARM;
            end
            S_ARM: begin
               if (confirm_ok && !err_vpp && !err_lock) begin
                  base_blk  <= arm_addr[AW-1:WORD_BITS];
                  start_ofs <= arm_addr[WORD_BITS-1:0];
                  tmr       <= TW'(SETUP_CYC - 1);
                  st        <= S_SETUP;
               end else if (bus_wr) begin
                  st <= S_IDLE;
               end
            end
            S_SETUP: begin
               if (tmr == '0) st <= S_PROG;
               else           tmr <= tmr - 1'b1;
            end
            S_PROG: begin
               if (stream_wr)     st <= S_PPULSE;
               else if (end_mark) st <= S_VERIFY;
            end
            S_PPULSE: if (pgm_done) st <= S_PROG;
            S_VERIFY: begin
               if (stream_wr) begin
                  vdata <= bus_wdata;
                  tries <= '0;
                  st    <= S_VCMP;
               end else if (end_mark) begin
                  tmr <= TW'(EXIT_CYC - 1);
                  st  <= S_EXIT;
               end
            end
            S_VCMP: begin
               if (pgm_req) begin
                  tries <= tries + 1'b1;
                  st    <= S_VPULSE;
               end else begin
                  st <= S_VERIFY;
               end
            end
            S_VPULSE: if (pgm_done) st <= S_VCMP;
            S_EXIT: begin
               if (tmr == '0) st <= S_IDLE;
               else           tmr <= tmr - 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   fpseq_ptr #(.WB(WORD_BITS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_val),
      .inc(ptr_inc), .ptr(ptr)
   );

   fpseq_array #(
      .AW(AW), .DW(DW), .PULSE_LAT(PULSE_LAT),
      .WEAK_MAP(WEAK_MAP), .STUCK_MAP(STUCK_MAP)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .pgm_req(pgm_req), .pgm_addr(word_addr),
      .pgm_data(pgm_data), .pgm_done(pgm_done), .rd_addr(word_addr),
      .rd_data(rd_data)
   );

   fpseq_status u_status (
      .clk(clk), .rst_n(rst_n), .set_fail(set_fail), .set_vpp(set_vpp),
      .set_lock(set_lock), .clr(clr_st),
      .rdy(!(st == S_SETUP || st == S_EXIT)),
      .busy(st == S_PPULSE || st == S_VCMP || st == S_VPULSE),
      .status(status)
   );

   // R2: setup holds for its full count before the stream opens
   p_setup_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SETUP && tmr != '0) |=> (st == S_SETUP))
      else $error("p_setup_hold_r2");

   // R3: a confirm without programming voltage never enters the mode
   p_no_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ARM && bus_wr && !hv_ok) |=> (st == S_IDLE))
      else $error("p_no_entry_r3");

   // R7: retries never exceed the bound
   p_retry_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_VPULSE) |-> (tries <= RW'(MAX_RETRY) && tries != '0))
      else $error("p_retry_bound_r7");

   // R8: the fail flag rises only out of a verify compare
   p_fail_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_FAIL]) |-> ($past(st) == S_VCMP))
      else $error("p_fail_src_r8");

   // R9: exit reports ready as soon as its count runs out
   p_exit_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_EXIT && tmr == '0) |=> status[ST_RDY])
      else $error("p_exit_ready_r9");
endmodule

// File: tb/fpseq_top_bench.sv
module fpseq_top_bench;
   localparam int WB  = 3;
   localparam int NB  = 2;
   localparam int AW  = 4;
   localparam int DW  = 16;
   localparam int LAT = 2;
   localparam int MR  = 3;
   localparam int SC  = 4;
   localparam int EC  = 3;

   localparam int BUSY_OK    = 1;
   localparam int BUSY_RETRY = LAT + 2;
   localparam int BUSY_FAIL  = MR * (LAT + 1) + 1;

   // stream vectors for block 1: {addr, data, verify busy cycles}
   localparam int NV = 8;
   localparam logic [AW+DW+7:0] VEC [NV] = '{
      {4'h8, 16'h1234, 8'(BUSY_OK)},
      {4'h8, 16'h0F0F, 8'(BUSY_OK)},
      {4'hA, 16'h00A5, 8'(BUSY_RETRY)},
      {4'hB, 16'h7FFE, 8'(BUSY_OK)},
      {4'h8, 16'hFFFF, 8'(BUSY_OK)},
      {4'hD, 16'h8001, 8'(BUSY_OK)},
      {4'hF, 16'h5555, 8'(BUSY_OK)},
      {4'h9, 16'hAAAA, 8'(BUSY_OK)}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          hv_ok = 1'b1;
   logic [NB-1:0] blk_lock = '0;
   logic [7:0]    status;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   fpseq_top u_fpseq_top (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .hv_ok(hv_ok), .blk_lock(blk_lock), .status(status)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (status[0] && n < 100) begin
         step(1);
         n++;
      end
   endtask

   task automatic enter(input logic [AW-1:0] a);
      wr(a, 16'h0030);
      wr(a, 16'h00D0);
      step(SC);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      step(2);
      chk(status == 8'h80, "R1 reset status", status, 8'h80);
      rst_n = 1'b1;
      step(1);
      chk(status == 8'h80, "R1 status after release", status, 8'h80);

      // R3 missing voltage
      hv_ok = 1'b0;
      wr(4'h8, 16'h0030);
      wr(4'h8, 16'h00D0);
      chk(status == 8'h88, "R3 voltage error", status, 8'h88);
      wr(4'h8, 16'h1234);
      chk(status == 8'h88, "R3 mode not entered", status, 8'h88);
      // R10 clear
      wr(4'h8, 16'h0050);
      chk(status == 8'h80, "R10 clear after voltage error", status, 8'h80);
      hv_ok = 1'b1;

      // R3 locked block
      blk_lock = 2'b10;
      wr(4'h8, 16'h0030);
      wr(4'h8, 16'h00D0);
      chk(status == 8'h82, "R3 lock error", status, 8'h82);
      wr(4'h8, 16'h0050);
      chk(status == 8'h80, "R10 clear after lock error", status, 8'h80);
      blk_lock = 2'b00;

      // R2 wrong confirm address aborts
      wr(4'h8, 16'h0030);
      wr(4'h9, 16'h00D0);
      wr(4'h8, 16'h4321);
      chk(status == 8'h80, "R2 abort leaves idle", status, 8'h80);

      // R2 setup timing
      wr(4'h8, 16'h0030);
      wr(4'h8, 16'h00D0);
      chk(status[7] == 1'b0, "R2 setup in progress", status, 8'h00);
      step(SC - 1);
      chk(status[7] == 1'b0, "R2 setup still in progress", status, 8'h00);
      step(1);
      chk(status == 8'h80, "R2 setup done", status, 8'h80);

      // R4 R5 program stream from the vector table
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][AW+DW+7:DW+8], VEC[i][DW+7:8]);
         chk(status[0] == 1'b1, "R4 busy after program write", status, 8'h81);
         busy_len(n);
         chk(n == LAT, "R4 program pulse length", n, LAT);
         if (i == 3) begin
            wr(4'h2, 16'h1111);
            chk(status == 8'h80, "R6 out-of-block non-ones ignored", status, 8'h80);
         end
      end

      // R6 end marker opens verify
      wr(4'h0, 16'hFFFF);
      chk(status == 8'h80, "R6 verify opened", status, 8'h80);

      // R5 R7 verify replay
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][AW+DW+7:DW+8], VEC[i][DW+7:8]);
         busy_len(n);
         chk(n == int'(VEC[i][7:0]), "R7 verify busy length", n, int'(VEC[i][7:0]));
      end

      // R9 exit
      wr(4'h0, 16'hFFFF);
      chk(status[7] == 1'b0, "R9 exit in progress", status, 8'h00);
      step(EC - 1);
      chk(status[7] == 1'b0, "R9 exit still in progress", status, 8'h00);
      step(1);
      chk(status == 8'h80, "R7 R9 clean exit without fail", status, 8'h80);

      // R8 stuck word in block 0, stream from offset 4
      enter(4'h4);
      wr(4'h4, 16'h0000); busy_len(n);
      wr(4'h4, 16'h0000); busy_len(n);
      wr(4'h4, 16'h3C3C); busy_len(n);
      wr(4'h8, 16'hFFFF);
      wr(4'h4, 16'h0000); busy_len(n);
      chk(n == BUSY_OK, "R5 first replayed word matches", n, BUSY_OK);
      wr(4'h4, 16'h0000); busy_len(n);
      chk(n == BUSY_FAIL, "R8 stuck word retry length", n, BUSY_FAIL);
      chk(status[4] == 1'b1, "R8 fail flag set", status, 8'h90);
      wr(4'h4, 16'h3C3C); busy_len(n);
      chk(n == BUSY_OK, "R5 pointer after failed word", n, BUSY_OK);
      wr(4'h8, 16'hFFFF);
      step(EC);
      chk(status == 8'h90, "R8 fail flag after exit", status, 8'h90);
      wr(4'h4, 16'h0050);
      chk(status == 8'h80, "R10 clear fail flag", status, 8'h80);

      // R8 replayed word that cannot be reached by clearing bits
      enter(4'h8);
      wr(4'h0, 16'hFFFF);
      wr(4'h8, 16'hFFFF); busy_len(n);
      chk(n == BUSY_FAIL, "R8 unreachable word retry length", n, BUSY_FAIL);
      wr(4'h0, 16'hFFFF);
      step(EC);
      chk(status == 8'h90, "R8 fail after unreachable word", status, 8'h90);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule